// File: doc/BRIEF.md
# List-Driven Scatter/Gather Data Mover

This block moves the data areas of one message between local memory and a peer across a packet link, for a single buffer set. It keeps no payload buffer. A start command names a list in memory that holds the base address of each data area. The command also gives the transfer direction, the number of areas and the length of each area. The block reads list entries one at a time. For every 128-byte slice of an area it issues one memory fetch or store, so each link packet maps one-to-one onto a memory operation.

The side that will receive data announces that it is ready with a header-only data-request packet. The sending side holds back all memory and link traffic until it has both its own command and that request. After the start, packets stream across list entries with no further exchange. A sequence number and an end-of-transfer flag travel with each packet, so the two ends can split the same data into differently shaped areas. Faulty packets, duplicate commands and failed memory operations are reported on single-cycle error outputs.

Top module: `sgm_mover`

## Requirements
- R1: After reset, `mreq_valid`, `tx_valid`, `done` and all three error outputs are low, and `rx_ready` is high.
- R2: With `cmd_dir`=0 (send), no memory request and no data packet (`tx_dreq`=0) appear until both the command and a received data-request packet (`rx_dreq`=1) have been taken. Either may come first.
- R3: With `cmd_dir`=1 (receive), the block first emits exactly one packet with `tx_dreq`=1, before any memory request.
- R4: List entry i is read from `cmd_list_addr + 8*i`. The low `AW` bits of that read's data are the area base, and slice k of the area is at `base + 128*k`. Every slice of one area is moved before the next entry is read. The area count is `cmd_areas_m1+1` and the slices per area are `cmd_len_m1+1`.
- R5: In send mode, each fetched slice goes out as one data packet whose `tx_data` equals the fetch data. `tx_seq` starts at 0 and steps by one modulo 2^SEQW. `tx_last`=1 only on the final packet of the whole transfer.
- R6: In receive mode, each accepted data packet becomes one store (`mreq_write`=1) whose `mreq_wdata` equals `rx_data`, at the next slice address.
- R7: `done` pulses for one cycle. In send mode this is the cycle the final packet is taken (`tx_ready`=1). In receive mode it is the cycle the final store's response returns status 0.
- R8: A received data packet whose `rx_seq` differs from the expected count is dropped, with no store and no error. The next packet accepted must carry the expected count.
- R9: A data packet with the expected count but `rx_size` other than 128 raises `err_proto` in its acceptance cycle, is not stored, and ends the transfer.
- R10: A data packet with the expected count whose `rx_last` disagrees with the local end of the list raises `err_proto`, is not stored, and ends the transfer.
- R11: A data-request packet taken while this side holds a receive command raises `err_proto` and has no other effect. A data packet taken while no slice is awaited raises `err_proto` and is discarded.
- R12: A command arriving while one is in progress (from acceptance through the cycle of `done` or an error end) raises `err_double` in that cycle and is ignored.
- R13: A memory response with nonzero `mrsp_status` raises `err_mem` in that cycle. Nothing from that operation goes onto the link, and the transfer ends without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start command strobe |
| cmd_dir | input | 1 | 0 send (memory to link), 1 receive (link to memory) |
| cmd_list_addr | input | AW | Memory address of the area list |
| cmd_areas_m1 | input | CW | Number of areas minus one |
| cmd_len_m1 | input | LW | Slices per area minus one |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 store, 0 fetch |
| mreq_addr | output | AW | Request address |
| mreq_wdata | output | DW | Store data |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_status | input | 2 | 0 ok; nonzero is a failure |
| mrsp_rdata | input | DW | Fetch data |
| tx_valid | output | 1 | Outgoing packet valid |
| tx_ready | input | 1 | Link takes the packet |
| tx_dreq | output | 1 | 1 data-request packet, 0 data packet |
| tx_last | output | 1 | Final packet of the transfer |
| tx_seq | output | SEQW | Packet sequence count |
| tx_data | output | DW | Slice payload token |
| rx_valid | input | 1 | Incoming packet valid |
| rx_ready | output | 1 | Block takes the incoming packet |
| rx_dreq | input | 1 | 1 data-request packet |
| rx_last | input | 1 | Final packet flag |
| rx_seq | input | SEQW | Packet sequence count |
| rx_size | input | SZW | Information field byte count |
| rx_data | input | DW | Slice payload token |
| done | output | 1 | Transfer finished |
| err_double | output | 1 | Second command while busy |
| err_proto | output | 1 | Link protocol violation |
| err_mem | output | 1 | Memory operation failed |

## Verification
The bench sends the peer request both before and after the local command. A gate that tested only one order would either stall or begin fetching early, and the early fetch shows up as an unexpected request. Sequence counts are driven past the wrap point with link stalls in between, and wrong counts are mixed into a receive stream. A design that stored a dropped packet, or that advanced its count on one, would produce an extra or misaddressed store. Wrong sizes, an early last flag and a failed fetch partway through an area must each end the transfer without `done` and without link output for the bad slice. A duplicate command must leave the first list address in use.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DREQ, ST_ENT_REQ, ST_ENT_RSP, ST_FET_REQ,
    ST_FET_RSP, ST_TX, ST_RX_WAIT, ST_STO_REQ, ST_STO_RSP
  } sgm_state_e;

  localparam logic       DIR_SEND = 1'b0;
  localparam logic       DIR_RECV = 1'b1;
  localparam logic [1:0] MEM_OK   = 2'b00;
endpackage

// File: rtl/sgm_start_gate.sv
module sgm_start_gate #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_dir,
  input  logic [AW-1:0] cmd_list_addr,
  input  logic [CW-1:0] cmd_areas_m1,
  input  logic [LW-1:0] cmd_len_m1,
  input  logic          dreq_acc,
  input  logic          finish,
  output logic          busy_o,
  output logic          dir_o,
  output logic [AW-1:0] list_o,
  output logic [CW-1:0] areas_o,
  output logic [LW-1:0] len_o,
  output logic          peer_o,
  output logic          go_o,
  output logic          err_double_o,
  output logic          dreq_misuse_o
);
  import sgm_pkg::*;

  logic          busy_q, dir_q, peer_q;
  logic [AW-1:0] list_q;
  logic [CW-1:0] areas_q;
  logic [LW-1:0] len_q;

  // named events
  logic cmd_take, peer_set;
  assign cmd_take      = cmd_valid && !busy_q;
  assign err_double_o  = cmd_valid && busy_q;
  assign dreq_misuse_o = dreq_acc && busy_q && (dir_q == DIR_RECV);
  assign peer_set      = dreq_acc && !dreq_misuse_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= DIR_SEND;
      peer_q  <= 1'b0;
      list_q  <= '0;
      areas_q <= '0;
      len_q   <= '0;
    end else begin
      if (finish) begin
        busy_q <= 1'b0;
      end else if (cmd_take) begin
        busy_q  <= 1'b1;
        dir_q   <= cmd_dir;
        list_q  <= cmd_list_addr;
        areas_q <= cmd_areas_m1;
        len_q   <= cmd_len_m1;
      end
      if (finish)        peer_q <= peer_set;
      else if (peer_set) peer_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign dir_o   = dir_q;
  assign list_o  = list_q;
  assign areas_o = areas_q;
  assign len_o   = len_q;
  assign peer_o  = peer_q;
  assign go_o    = busy_q && ((dir_q == DIR_RECV) || peer_q);

  // R12: a command arriving while busy leaves the held command untouched
  assert_double_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_q && !finish) |=> ($stable(list_q) && $stable(dir_q) && busy_q));
endmodule

// File: rtl/sgm_rx_check.sv
module sgm_rx_check #(
  parameter int SEQW      = 3,
  parameter int SZW       = 8,
  parameter int PKT_BYTES = 128
) (
  input  logic [SEQW-1:0] rx_seq,
  input  logic [SZW-1:0]  rx_size,
  input  logic            rx_last,
  input  logic [SEQW-1:0] exp_seq,
  input  logic            exp_last,
  output logic            seq_ok,
  output logic            size_ok,
  output logic            last_ok
);
  function automatic logic size_match(logic [SZW-1:0] sz);
    return sz == SZW'(PKT_BYTES);
  endfunction

  assign seq_ok  = (rx_seq == exp_seq);
  assign size_ok = size_match(rx_size);
  assign last_ok = (rx_last == exp_last);
endmodule

// File: rtl/sgm_engine.sv
module sgm_engine #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 4,
  parameter int LW          = 4,
  parameter int SEQW        = 3,
  parameter int PKT_BYTES   = 128,
  parameter int ENTRY_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            dir_i,
  input  logic [AW-1:0]   list_i,
  input  logic [CW-1:0]   areas_i,
  input  logic [LW-1:0]   len_i,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic            mreq_write,
  output logic [AW-1:0]   mreq_addr,
  output logic [DW-1:0]   mreq_wdata,
  input  logic            mrsp_valid,
  input  logic [1:0]      mrsp_status,
  input  logic [DW-1:0]   mrsp_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            tx_dreq,
  output logic            tx_last,
  output logic [SEQW-1:0] tx_seq,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  input  logic            rx_dreq,
  input  logic [DW-1:0]   rx_data,
  input  logic            seq_ok,
  input  logic            size_ok,
  input  logic            last_ok,
  output logic            rx_wait_o,
  output logic [SEQW-1:0] exp_seq_o,
  output logic            exp_last_o,
  output logic            done_o,
  output logic            mem_err_o,
  output logic            proto_abort_o
);
  import sgm_pkg::*;

  sgm_state_e      state_q;
  logic [CW-1:0]   area_q;
  logic [LW-1:0]   pkt_q;
  logic [SEQW-1:0] seq_q;
  logic [AW-1:0]   base_q;
  logic [DW-1:0]   hold_q;

  function automatic logic [AW-1:0] entry_addr(logic [AW-1:0] list, logic [CW-1:0] idx);
    return list + AW'(idx) * AW'(ENTRY_BYTES);
  endfunction

  function automatic logic [AW-1:0] slice_addr(logic [AW-1:0] base, logic [LW-1:0] k);
    return base + AW'(k) * AW'(PKT_BYTES);
  endfunction

  // named internal events
  logic in_rsp, rsp_ok, rsp_bad, area_end, final_pkt, rx_data_ev, rx_good, rx_drop;
  assign in_rsp     = (state_q == ST_ENT_RSP) || (state_q == ST_FET_RSP) || (state_q == ST_STO_RSP);
  assign rsp_ok     = mrsp_valid && (mrsp_status == MEM_OK);
  assign rsp_bad    = in_rsp && mrsp_valid && (mrsp_status != MEM_OK);
  assign area_end   = (pkt_q == len_i);
  assign final_pkt  = area_end && (area_q == areas_i);
  assign rx_data_ev = (state_q == ST_RX_WAIT) && rx_valid && !rx_dreq;
  assign rx_drop    = rx_data_ev && !seq_ok;
  assign rx_good    = rx_data_ev && seq_ok && size_ok && last_ok;

  // step to the following slice once the current one is complete
  sgm_state_e    step_state;
  logic [CW-1:0] step_area;
  logic [LW-1:0] step_pkt;
  always_comb begin
    step_area = area_q;
    step_pkt  = pkt_q + 1'b1;
    if (final_pkt) begin
      step_state = ST_IDLE;
    end else if (area_end) begin
      step_state = ST_ENT_REQ;
      step_area  = area_q + 1'b1;
      step_pkt   = '0;
    end else begin
      step_state = (dir_i == DIR_RECV) ? ST_RX_WAIT : ST_FET_REQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      area_q  <= '0;
      pkt_q   <= '0;
      seq_q   <= '0;
      base_q  <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          area_q  <= '0;
          pkt_q   <= '0;
          seq_q   <= '0;
          state_q <= (dir_i == DIR_RECV) ? ST_DREQ : ST_ENT_REQ;
        end
        ST_DREQ:    if (tx_ready) state_q <= ST_ENT_REQ;
        ST_ENT_REQ: if (mreq_ready) state_q <= ST_ENT_RSP;
        ST_ENT_RSP: if (mrsp_valid) begin
          if (rsp_ok) begin
            base_q  <= AW'(mrsp_rdata);
            pkt_q   <= '0;
            state_q <= (dir_i == DIR_RECV) ? ST_RX_WAIT : ST_FET_REQ;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_FET_REQ: if (mreq_ready) state_q <= ST_FET_RSP;
        ST_FET_RSP: if (mrsp_valid) begin
          if (rsp_ok) begin
            hold_q  <= mrsp_rdata;
            state_q <= ST_TX;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_TX: if (tx_ready) begin
          seq_q   <= seq_q + 1'b1;
          area_q  <= step_area;
          pkt_q   <= step_pkt;
          state_q <= step_state;
        end
        ST_RX_WAIT: if (rx_data_ev && seq_ok) begin
          if (rx_good) begin
            hold_q  <= rx_data;
            seq_q   <= seq_q + 1'b1;
            state_q <= ST_STO_REQ;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_STO_REQ: if (mreq_ready) state_q <= ST_STO_RSP;
        ST_STO_RSP: if (mrsp_valid) begin
          if (rsp_ok) begin
            area_q  <= step_area;
            pkt_q   <= step_pkt;
            state_q <= step_state;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mreq_valid = (state_q == ST_ENT_REQ) || (state_q == ST_FET_REQ) || (state_q == ST_STO_REQ);
  assign mreq_write = (state_q == ST_STO_REQ);
  assign mreq_addr  = (state_q == ST_ENT_REQ) ? entry_addr(list_i, area_q) : slice_addr(base_q, pkt_q);
  assign mreq_wdata = hold_q;

  assign tx_valid = (state_q == ST_DREQ) || (state_q == ST_TX);
  assign tx_dreq  = (state_q == ST_DREQ);
  assign tx_last  = (state_q == ST_TX) && final_pkt;
  assign tx_seq   = (state_q == ST_TX) ? seq_q : '0;
  assign tx_data  = (state_q == ST_TX) ? hold_q : '0;

  assign rx_wait_o     = (state_q == ST_RX_WAIT);
  assign exp_seq_o     = seq_q;
  assign exp_last_o    = final_pkt;
  assign mem_err_o     = rsp_bad;
  assign proto_abort_o = rx_data_ev && seq_ok && !(size_ok && last_ok);
  assign done_o        = ((state_q == ST_TX) && tx_ready && final_pkt) ||
                         ((state_q == ST_STO_RSP) && rsp_ok && final_pkt);

  // R4: a waiting memory request holds its address and kind
  assert_mreq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_write)));
  // R5: a waiting link packet holds its fields
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_seq) && $stable(tx_last) && $stable(tx_data)));
  // R8: a packet with the wrong count leaves the block waiting with the same count
  assert_seq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> (rx_wait_o && $stable(exp_seq_o)));
  // R9 / R10: a malformed packet ends the transfer without a store
  assert_proto_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_abort_o |=> (!mreq_valid && !tx_valid && state_q == ST_IDLE));
  // R13: a failed memory operation sends nothing onto the link
  assert_mem_err_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err_o |=> (!tx_valid && !mreq_valid));
  // R7: done and an error end never coincide
  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, mem_err_o, proto_abort_o}));
endmodule

// File: rtl/sgm_mover.sv
module sgm_mover #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 4,
  parameter int LW          = 4,
  parameter int SEQW        = 3,
  parameter int PKT_BYTES   = 128,
  parameter int ENTRY_BYTES = 8,
  parameter int SZW         = $clog2(PKT_BYTES) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_dir,
  input  logic [AW-1:0]   cmd_list_addr,
  input  logic [CW-1:0]   cmd_areas_m1,
  input  logic [LW-1:0]   cmd_len_m1,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic            mreq_write,
  output logic [AW-1:0]   mreq_addr,
  output logic [DW-1:0]   mreq_wdata,
  input  logic            mrsp_valid,
  input  logic [1:0]      mrsp_status,
  input  logic [DW-1:0]   mrsp_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            tx_dreq,
  output logic            tx_last,
  output logic [SEQW-1:0] tx_seq,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic            rx_dreq,
  input  logic            rx_last,
  input  logic [SEQW-1:0] rx_seq,
  input  logic [SZW-1:0]  rx_size,
  input  logic [DW-1:0]   rx_data,
  output logic            done,
  output logic            err_double,
  output logic            err_proto,
  output logic            err_mem
);
  import sgm_pkg::*;

  logic            g_busy, g_dir, g_peer, g_go, g_misuse;
  logic [AW-1:0]   g_list;
  logic [CW-1:0]   g_areas;
  logic [LW-1:0]   g_len;
  logic            e_rx_wait, e_exp_last, e_done, e_mem_err, e_abort;
  logic [SEQW-1:0] e_exp_seq;
  logic            c_seq_ok, c_size_ok, c_last_ok;

  // named link events
  logic dreq_acc, stray_data, finish;
  assign rx_ready   = !(g_busy && (g_dir == DIR_RECV)) || e_rx_wait;
  assign dreq_acc   = rx_valid && rx_ready && rx_dreq;
  assign stray_data = rx_valid && rx_ready && !rx_dreq && !e_rx_wait;
  assign finish     = e_done || e_mem_err || e_abort;

  sgm_start_gate #(.AW(AW), .CW(CW), .LW(LW)) u_gate (
    .clk, .rst_n, .cmd_valid, .cmd_dir, .cmd_list_addr, .cmd_areas_m1, .cmd_len_m1,
    .dreq_acc, .finish,
    .busy_o(g_busy), .dir_o(g_dir), .list_o(g_list), .areas_o(g_areas), .len_o(g_len),
    .peer_o(g_peer), .go_o(g_go), .err_double_o(err_double), .dreq_misuse_o(g_misuse)
  );

  sgm_rx_check #(.SEQW(SEQW), .SZW(SZW), .PKT_BYTES(PKT_BYTES)) u_chk (
    .rx_seq, .rx_size, .rx_last, .exp_seq(e_exp_seq), .exp_last(e_exp_last),
    .seq_ok(c_seq_ok), .size_ok(c_size_ok), .last_ok(c_last_ok)
  );

  sgm_engine #(.AW(AW), .DW(DW), .CW(CW), .LW(LW), .SEQW(SEQW),
               .PKT_BYTES(PKT_BYTES), .ENTRY_BYTES(ENTRY_BYTES)) u_eng (
    .clk, .rst_n, .go(g_go), .dir_i(g_dir), .list_i(g_list), .areas_i(g_areas), .len_i(g_len),
    .mreq_valid, .mreq_ready, .mreq_write, .mreq_addr, .mreq_wdata,
    .mrsp_valid, .mrsp_status, .mrsp_rdata,
    .tx_valid, .tx_ready, .tx_dreq, .tx_last, .tx_seq, .tx_data,
    .rx_valid, .rx_dreq, .rx_data,
    .seq_ok(c_seq_ok), .size_ok(c_size_ok), .last_ok(c_last_ok),
    .rx_wait_o(e_rx_wait), .exp_seq_o(e_exp_seq), .exp_last_o(e_exp_last),
    .done_o(e_done), .mem_err_o(e_mem_err), .proto_abort_o(e_abort)
  );

  assign done      = e_done;
  assign err_mem   = e_mem_err;
  assign err_proto = e_abort || g_misuse || stray_data;

  // R2: a data packet leaves only in send mode after the peer has asked
  assert_gate_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_dreq) |-> (g_peer && g_busy && g_dir == DIR_SEND));
  // R2: no memory traffic on the send side before the peer has asked
  assert_no_early_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && g_dir == DIR_SEND) |-> g_peer);
  // R3: a data-request packet leaves only from a receive command
  assert_dreq_from_recv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_dreq) |-> (g_busy && g_dir == DIR_RECV));
  // R11: a misplaced data request does not end the transfer
  assert_misuse_keeps_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (g_misuse && !finish) |=> g_busy);
endmodule

// File: tb/sgm_mover_tb.sv
module sgm_mover_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_dir = 1'b0;
  logic [31:0] cmd_list_addr = '0;
  logic [3:0]  cmd_areas_m1 = '0, cmd_len_m1 = '0;
  logic        mreq_valid, mreq_ready = 1'b1, mreq_write;
  logic [31:0] mreq_addr, mreq_wdata;
  logic        mrsp_valid = 1'b0;
  logic [1:0]  mrsp_status = '0;
  logic [31:0] mrsp_rdata = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_dreq, tx_last;
  logic [2:0]  tx_seq;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready, rx_dreq = 1'b0, rx_last = 1'b0;
  logic [2:0]  rx_seq = '0;
  logic [7:0]  rx_size = '0;
  logic [31:0] rx_data = '0;
  logic        done, err_double, err_proto, err_mem;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgm_mover u_dut (.*);

  typedef struct packed { logic w; logic [31:0] a; logic [31:0] d; } mexp_t;
  typedef struct packed { logic dq; logic last; logic [2:0] seq; logic [31:0] d; } texp_t;
  mexp_t mq[$];
  texp_t tq[$];

  int total = 0, bad = 0;
  int n_done = 0, n_proto = 0, n_dbl = 0, n_mem = 0, n_mhs = 0, n_txhs = 0;
  logic [31:0] bad_addr = 32'hFFFF_FFF0;

  function automatic logic [31:0] rd(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h3C3C_0000;
  endfunction
  function automatic logic [31:0] pd(int n);
    return 32'hD00D_0000 + 32'(n);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor and memory responder
  initial begin
    logic        pend;
    logic [31:0] pa;
    pend = 1'b0; pa = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) n_done++;
        if (err_proto) n_proto++;
        if (err_double) n_dbl++;
        if (err_mem) n_mem++;
        if (mreq_valid && mreq_ready) begin
          n_mhs++;
          pend = 1'b1; pa = mreq_addr;
          if (mq.size() == 0) chk(0, "R4 unexpected memory request", mreq_addr, 0);
          else begin
            mexp_t e;
            e = mq.pop_front();
            chk(mreq_write == e.w && mreq_addr == e.a, "R4 memory request addr", mreq_addr, e.a);
            if (e.w) chk(mreq_wdata == e.d, "R6 store data", mreq_wdata, e.d);
          end
        end
        if (tx_valid && tx_ready) begin
          n_txhs++;
          if (tq.size() == 0) chk(0, "R2 unexpected link packet", tx_data, 0);
          else begin
            texp_t t;
            t = tq.pop_front();
            if (t.dq) chk(tx_dreq == 1'b1, "R3 data-request packet", 32'(tx_dreq), 1);
            else chk(!tx_dreq && tx_last == t.last && tx_seq == t.seq && tx_data == t.d,
                     "R5 data packet", {tx_last, tx_seq, tx_data[27:0]}, {t.last, t.seq, t.d[27:0]});
          end
        end
      end
      @(posedge clk); #1;
      mrsp_valid  = pend;
      mrsp_rdata  = pend ? rd(pa) : '0;
      mrsp_status = (pend && pa == bad_addr) ? 2'd1 : 2'd0;
      pend = 1'b0;
    end
  end

  task automatic send_cmd(bit dir, logic [31:0] list, logic [3:0] am1, logic [3:0] lm1);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_dir = dir; cmd_list_addr = list; cmd_areas_m1 = am1; cmd_len_m1 = lm1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic rx_pkt(bit dq, bit last, logic [2:0] seq, logic [7:0] size, logic [31:0] d);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_dreq = dq; rx_last = last; rx_seq = seq; rx_size = size; rx_data = d;
    forever begin
      @(negedge clk);
      if (rx_ready) break;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic exp_send(logic [31:0] list, int am1, int lm1);
    int s = 0;
    for (int a = 0; a <= am1; a++) begin
      logic [31:0] ea, base;
      ea = list + 32'(8 * a);
      mq.push_back('{1'b0, ea, 32'h0});
      base = rd(ea);
      for (int k = 0; k <= lm1; k++) begin
        logic [31:0] sa;
        sa = base + 32'(128 * k);
        mq.push_back('{1'b0, sa, 32'h0});
        tq.push_back('{1'b0, (a == am1 && k == lm1), 3'(s), rd(sa)});
        s++;
      end
    end
  endtask

  task automatic exp_recv(logic [31:0] list, int am1, int lm1);
    int n = 0;
    tq.push_back('{1'b1, 1'b0, 3'd0, 32'h0});
    for (int a = 0; a <= am1; a++) begin
      logic [31:0] ea, base;
      ea = list + 32'(8 * a);
      mq.push_back('{1'b0, ea, 32'h0});
      base = rd(ea);
      for (int k = 0; k <= lm1; k++) begin
        mq.push_back('{1'b1, base + 32'(128 * k), pd(n)});
        n++;
      end
    end
  endtask

  task automatic wait_done(int target);
    for (int i = 0; i < 3000 && n_done < target; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic queues_empty(string tag);
    chk(mq.size() == 0 && tq.size() == 0, tag, 32'(mq.size() + tq.size()), 0);
    mq.delete(); tq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m0, t0, p0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mreq_valid && !tx_valid && rx_ready && !done && !err_proto && !err_double && !err_mem,
        "R1 reset outputs", {mreq_valid, tx_valid, rx_ready, done}, 4'b0010);

    // R11 stray data packet while idle
    p0 = n_proto; m0 = n_mhs;
    rx_pkt(0, 0, 3'd0, 8'd128, 32'h1234);
    repeat (3) @(negedge clk);
    chk(n_proto == p0 + 1 && n_mhs == m0, "R11 stray data while idle", n_proto - p0, 1);

    // R2 command first, then peer request; R4 R5 R7 two areas of three slices
    exp_send(32'h100, 1, 2);
    m0 = n_mhs; t0 = n_txhs;
    send_cmd(0, 32'h100, 4'd1, 4'd2);
    repeat (10) @(negedge clk);
    chk(n_mhs == m0 && n_txhs == t0, "R2 held until peer request", n_mhs - m0 + n_txhs - t0, 0);
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    wait_done(1);
    chk(n_done == 1, "R7 done after send", n_done, 1);
    queues_empty("R4 send walk complete");

    // R2 peer request first, then command; R5 sequence wrap under link stalls
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    exp_send(32'h1000, 0, 9);
    send_cmd(0, 32'h1000, 4'd0, 4'd9);
    fork
      begin
        for (int i = 0; i < 30; i++) begin @(posedge clk); #1; tx_ready = ~tx_ready; end
        tx_ready = 1'b1;
      end
    join_none
    wait_done(2);
    chk(n_done == 2, "R5 done after wrapped sequence", n_done, 2);
    queues_empty("R5 wrapped send complete");

    // R3 R6 receive three areas of one slice
    exp_recv(32'h200, 2, 0);
    send_cmd(1, 32'h200, 4'd2, 4'd0);
    rx_pkt(0, 0, 3'd0, 8'd128, pd(0));
    rx_pkt(0, 0, 3'd1, 8'd128, pd(1));
    rx_pkt(0, 1, 3'd2, 8'd128, pd(2));
    wait_done(3);
    chk(n_done == 3, "R7 done after receive", n_done, 3);
    queues_empty("R6 receive stores complete");

    // R8 wrong counts dropped; R11 data request during receive
    p0 = n_proto;
    exp_recv(32'h800, 0, 1);
    send_cmd(1, 32'h800, 4'd0, 4'd1);
    rx_pkt(0, 0, 3'd1, 8'd128, 32'hBAD0);
    rx_pkt(0, 0, 3'd0, 8'd128, pd(0));
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    rx_pkt(0, 1, 3'd3, 8'd128, 32'hBAD1);
    rx_pkt(0, 1, 3'd1, 8'd128, pd(1));
    wait_done(4);
    chk(n_proto == p0 + 1, "R11 data request while receiving", n_proto - p0, 1);
    chk(n_done == 4, "R8 transfer completes after drops", n_done, 4);
    queues_empty("R8 only expected stores");

    // R9 wrong size
    p0 = n_proto;
    mq.push_back('{1'b0, 32'h600, 32'h0});
    tq.push_back('{1'b1, 1'b0, 3'd0, 32'h0});
    send_cmd(1, 32'h600, 4'd0, 4'd1);
    rx_pkt(0, 0, 3'd0, 8'd64, 32'hBAD2);
    repeat (10) @(negedge clk);
    chk(n_proto == p0 + 1 && n_done == 4, "R9 size error", n_proto - p0, 1);
    queues_empty("R9 no store after size error");

    // R10 early last flag
    p0 = n_proto;
    mq.push_back('{1'b0, 32'h700, 32'h0});
    tq.push_back('{1'b1, 1'b0, 3'd0, 32'h0});
    send_cmd(1, 32'h700, 4'd1, 4'd1);
    rx_pkt(0, 1, 3'd0, 8'd128, 32'hBAD3);
    repeat (10) @(negedge clk);
    chk(n_proto == p0 + 1 && n_done == 4, "R10 last flag mismatch", n_proto - p0, 1);
    queues_empty("R10 no store after last mismatch");

    // R12 duplicate command ignored
    exp_send(32'h400, 0, 1);
    send_cmd(0, 32'h400, 4'd0, 4'd1);
    send_cmd(0, 32'h500, 4'd3, 4'd3);
    chk(n_dbl == 1, "R12 double command flagged", n_dbl, 1);
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    wait_done(5);
    chk(n_done == 5, "R12 first command completes", n_done, 5);
    queues_empty("R12 first list used");

    // R13 failed fetch in the middle of an area
    begin
      logic [31:0] base;
      base = rd(32'h300);
      bad_addr = base + 32'd128;
      mq.push_back('{1'b0, 32'h300, 32'h0});
      mq.push_back('{1'b0, base, 32'h0});
      tq.push_back('{1'b0, 1'b0, 3'd0, rd(base)});
      mq.push_back('{1'b0, base + 32'd128, 32'h0});
    end
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    send_cmd(0, 32'h300, 4'd0, 4'd3);
    repeat (30) @(negedge clk);
    chk(n_mem == 1 && n_done == 5, "R13 memory error ends transfer", n_mem, 1);
    queues_empty("R13 nothing sent after failure");
    bad_addr = 32'hFFFF_FFF0;

    // idle again after all error ends: a fresh command is not a double
    exp_send(32'h900, 0, 0);
    send_cmd(0, 32'h900, 4'd0, 4'd0);
    rx_pkt(1, 0, 3'd0, 8'd0, 32'h0);
    wait_done(6);
    chk(n_dbl == 1 && n_done == 6, "R12 idle after error ends", n_dbl, 1);
    queues_empty("R4 final transfer");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule